// File: doc/BRIEF.md
# Sync-Marker and Convolutional Symbol Coder

This block feeds a downlink modulator with coded symbol pairs. In data mode it takes payload bytes from an upstream FIFO over a valid/ready handshake and sends each byte out bit by bit, most significant bit first. In synchronisation mode it ignores the FIFO and repeats a fixed 32-bit marker, so that a ground receiver can lock before payload arrives. Every source bit passes through three stages in order: a self-synchronising scrambler, a differential encoder, and a rate-1/2, constraint-length-7 convolutional encoder. Each bit gives one registered two-bit symbol and a one-cycle strobe.

The output bit rate is the clock rate divided by 1, 2, 4 or 8, chosen by a two-bit select. The enable input follows the power amplifier. While it is low no bits are produced and no bytes are taken. The coder keeps its scrambler, differential and shift-register state across disabled periods. The source always restarts at the beginning of a byte or of the marker. If the FIFO is empty at a byte boundary, the block inserts a zero byte instead of stalling the symbol stream.

The source is a three-state machine: `SRC_IDLE` (disabled), `SRC_DATA` (serialising bytes) and `SRC_SYNC` (serialising the marker). Its transitions are: start-data (IDLE to DATA when enabled in data mode), start-sync (IDLE to SYNC when enabled in sync mode), to-sync (DATA to SYNC after the eighth bit of a byte while sync mode is requested), to-data (SYNC to DATA after the 32nd marker bit while data mode is requested), and stop (DATA or SYNC to IDLE whenever enable is low).

Top module: `sync_conv_coder`

## Requirements
- R1: While reset is asserted, and afterwards until the first bit is produced, `sym_vld_o`, `in_ready_o` and `sym_o` are all zero.
- R2: While enabled with a steady `rate_sel_i` of value r, successive strobes on `sym_vld_o` are exactly 2^r clock cycles apart (r = 0 gives one strobe per cycle).
- R3: While `en_i` is low, and in the cycle after it goes low, no strobe is produced and `in_ready_o` stays low.
- R4: In synchronisation mode (`sync_mode_i` = 1) the source bit stream is the 32-bit value 0x1ACFFC1D repeated, bit 31 first, and `in_ready_o` never rises, so no FIFO byte is consumed.
- R5: In data mode (`sync_mode_i` = 0) `in_ready_o` is high for one cycle at the first bit of each byte. A byte is taken when `in_valid_i` and `in_ready_o` are both high, and is sent bit 7 first.
- R6: If `in_valid_i` is low at a byte boundary in data mode, the eight source bits of that byte are zero.
- R7: Source bit b[n] is scrambled as s[n] = b[n] XOR s[n-3] XOR s[n-20]. All earlier s values are zero after reset.
- R8: The differential output is d[n] = s[n] XOR d[n-1], with d[-1] = 0 after reset.
- R9: Each d[n] gives `sym_o[1]` = parity of generator 171 (octal) and `sym_o[0]` = parity of generator 133 (octal) over the window d[n], d[n-1] ... d[n-6]. The generator's most significant bit multiplies d[n]. Earlier values are zero after reset. The symbol and its strobe appear the cycle after the bit's tick.
- R10: A change of `sync_mode_i` takes effect only at a unit boundary: after the eighth bit of a byte, or after the 32nd bit of the marker.
- R11: Dropping `en_i` discards any partly sent byte or marker, and the next enabled period starts a fresh unit. The scrambler, differential and convolutional states carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Output enable, tied to amplifier activation |
| sync_mode_i | input | 1 | 1 = repeat sync marker, 0 = payload bytes |
| rate_sel_i | input | 2 | Bit-rate divider exponent (divide by 1, 2, 4, 8) |
| in_valid_i | input | 1 | FIFO byte available |
| in_data_i | input | 8 | FIFO byte |
| in_ready_o | output | 1 | Byte accepted this cycle when valid is also high |
| sym_o | output | 2 | Coded symbol pair, bit 1 = G1 output, bit 0 = G2 output |
| sym_vld_o | output | 1 | One-cycle strobe marking a new symbol pair |

## Verification
The coding chain is driven with the marker, with bytes of all ones, all zeros, alternating bits and mixed patterns, and with inserted fill zeros. Long runs of zeros show whether the scrambler feedback taps are right, because its state stays non-zero. The repeating marker shows whether the differential and convolutional history carry correctly from one period to the next. Mode switches requested in the middle of a byte and in the middle of a marker show whether a switch waits for the unit boundary. An enable drop after four bits shows that partial units are discarded while coder state is kept. Runs at every rate select separate the divider's spacing from the coder's content.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_DATA = 2'd1,
        SRC_SYNC = 2'd2
    } src_state_e;

    localparam int MARK_W = 32;
    localparam logic [MARK_W-1:0] SYNC_MARK = 32'h1ACF_FC1D;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/fsc_rate_div.sv
module fsc_rate_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int CNT_W  = (1 << SEL_W) - 1;
    localparam int SPAN_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] limit;

    always_comb begin
        span   = SPAN_W'(1) << sel_i;
        limit  = span - SPAN_W'(1);
        tick_o = run_i && ({1'b0, cnt_q} >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel_i != '0) |=> (!tick_o || !$stable(sel_i)));  // R2

endmodule

// File: rtl/fsc_bit_source.sv
module fsc_bit_source
    import fsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sync_mode_i,
    input  logic              tick_i,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              bit_o,
    output logic              active_o
);
    localparam int BCNT_W = $clog2(BYTE_W);
    localparam int MIDX_W = $clog2(MARK_W);
    localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(BYTE_W - 1);
    localparam logic [MIDX_W-1:0] MIDX_LAST = MIDX_W'(MARK_W - 1);

    src_state_e         state_q, state_d;
    logic [BCNT_W-1:0]  bcnt_q;
    logic [MIDX_W-1:0]  midx_q;
    logic [BYTE_W-1:0]  byte_q;
    logic [BYTE_W-1:0]  load_byte;
    logic               take;
    logic               byte_end;
    logic               mark_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign byte_end = tick_i && (bcnt_q == BCNT_LAST);
    assign mark_end = tick_i && (midx_q == MIDX_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: begin
                if (en_i) begin
                    state_d = sync_mode_i ? SRC_SYNC : SRC_DATA;
                end
            end
            SRC_DATA: begin
                if (!en_i) begin
                    state_d = SRC_IDLE;
                end else if (byte_end && sync_mode_i) begin
                    state_d = SRC_SYNC;
                end
            end
            SRC_SYNC: begin
                if (!en_i) begin
                    state_d = SRC_IDLE;
                end else if (mark_end && !sync_mode_i) begin
                    state_d = SRC_DATA;
                end
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready_o = 1'b0;
        bit_o      = 1'b0;
        active_o   = 1'b0;
        unique case (state_q)
            SRC_IDLE: begin
                active_o = 1'b0;
            end
            SRC_DATA: begin
                active_o   = 1'b1;
                in_ready_o = tick_i && (bcnt_q == '0);
                bit_o      = (bcnt_q == '0) ? (in_valid_i && in_data_i[BYTE_W-1])
                                            : byte_q[BYTE_W-1];
            end
            SRC_SYNC: begin
                active_o = 1'b1;
                bit_o    = SYNC_MARK[MIDX_LAST - midx_q];
            end
            default: begin
                active_o = 1'b0;
            end
        endcase
    end

    assign take      = in_ready_o && in_valid_i;
    assign load_byte = take ? in_data_i : '0;

    // counters and byte shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt_q <= '0;
            midx_q <= '0;
            byte_q <= '0;
        end else begin
            if (state_q != SRC_DATA) begin
                bcnt_q <= '0;
            end else if (tick_i) begin
                bcnt_q <= bcnt_q + BCNT_W'(1);
            end

            if (state_q != SRC_SYNC) begin
                midx_q <= '0;
            end else if (tick_i) begin
                midx_q <= midx_q + MIDX_W'(1);
            end

            if (state_q == SRC_DATA && tick_i) begin
                byte_q <= (bcnt_q == '0) ? {load_byte[BYTE_W-2:0], 1'b0}
                                         : {byte_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    AST_ENTER_SYNC_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_SYNC && $past(state_q) == SRC_DATA)
            |-> ($past(bcnt_q) == BCNT_LAST && $past(tick_i)));  // R10
    AST_ENTER_DATA_AT_MARK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_DATA && $past(state_q) == SRC_SYNC)
            |-> ($past(midx_q) == MIDX_LAST && $past(tick_i)));  // R10
    AST_STOP_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (state_q == SRC_IDLE));  // R3

endmodule

// File: rtl/fsc_scrambler.sv
module fsc_scrambler #(
    parameter int LEN = 20,
    parameter int TAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic bit_i,
    output logic bit_o
);
    logic [LEN-1:0] hist_q;

    assign bit_o = bit_i ^ hist_q[TAP-1] ^ hist_q[LEN-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (adv_i) begin
            hist_q <= {hist_q[LEN-2:0], bit_o};
        end
    end

    AST_SCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(hist_q));  // R11

endmodule

// File: rtl/fsc_diff_enc.sv
module fsc_diff_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic bit_i,
    output logic bit_o
);
    logic prev_q;

    assign bit_o = bit_i ^ prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (adv_i) begin
            prev_q <= bit_o;
        end
    end

    AST_DIFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(prev_q));  // R11

endmodule

// File: rtl/fsc_conv_enc.sv
module fsc_conv_enc #(
    parameter int          K  = 7,
    parameter logic [K-1:0] G1 = 7'o171,
    parameter logic [K-1:0] G2 = 7'o133
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       bit_i,
    output logic [1:0] sym_o,
    output logic       vld_o
);
    localparam int M    = K - 1;
    localparam int NOUT = 2;
    localparam logic [NOUT-1:0][K-1:0] GENS = {G1, G2};

    logic [M-1:0]    hist_q;
    logic [K-1:0]    window;
    logic [NOUT-1:0] parity;
    logic [1:0]      sym_q;
    logic            vld_q;

    assign window = {bit_i, hist_q};

    for (genvar g = 0; g < NOUT; g++) begin : g_par
        assign parity[g] = ^(window & GENS[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            sym_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= adv_i;
            if (adv_i) begin
                hist_q <= {bit_i, hist_q[M-1:1]};
                sym_q  <= parity;
            end
        end
    end

    assign sym_o = sym_q;
    assign vld_o = vld_q;

    AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> ($stable(hist_q) && !vld_q));  // R11

endmodule

// File: rtl/sync_conv_coder.sv
module sync_conv_coder
    import fsc_pkg::*;
#(
    parameter int SEL_W   = 2,
    parameter int K       = 7,
    parameter int SCR_LEN = 20,
    parameter int SCR_TAP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sync_mode_i,
    input  logic [SEL_W-1:0]  rate_sel_i,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic [1:0]        sym_o,
    output logic              sym_vld_o
);
    logic active;
    logic tick;
    logic src_bit;
    logic scr_bit;
    logic dif_bit;

    fsc_rate_div #(.SEL_W(SEL_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (en_i && active),
        .sel_i  (rate_sel_i),
        .tick_o (tick)
    );

    fsc_bit_source u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .sync_mode_i (sync_mode_i),
        .tick_i      (tick),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .in_ready_o  (in_ready_o),
        .bit_o       (src_bit),
        .active_o    (active)
    );

    fsc_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (tick),
        .bit_i (src_bit),
        .bit_o (scr_bit)
    );

    fsc_diff_enc u_dif (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (tick),
        .bit_i (scr_bit),
        .bit_o (dif_bit)
    );

    fsc_conv_enc #(.K(K)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (tick),
        .bit_i (dif_bit),
        .sym_o (sym_o),
        .vld_o (sym_vld_o)
    );

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !sym_vld_o);  // R3
    AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> sym_vld_o);  // R9
    AST_READY_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> tick);  // R5
    AST_READY_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !in_ready_o);  // R3

endmodule

// File: tb/sync_conv_coder_tb.sv
module sync_conv_coder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [31:0] MARK = 32'h1ACF_FC1D;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       sync_mode;
    logic [1:0] rate_sel;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic [1:0] sym;
    logic       sym_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_conv_coder u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .sync_mode_i (sync_mode),
        .rate_sel_i  (rate_sel),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_ready_o  (in_ready),
        .sym_o       (sym),
        .sym_vld_o   (sym_vld)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc_n = 0;

    // expected source bits and their requirement tags
    logic  exp_bits [0:1023];
    string exp_tag  [0:1023];
    int    exp_len, exp_pos;

    // FIFO feed
    logic [7:0] src_bytes [0:15];
    int src_n, src_idx, n_acc, rdy_seen;
    logic hs_pend;

    // run bookkeeping
    int target_g, run_strobes, last_cyc, exp_gap;

    // reference coder state
    logic [19:0] m_scr;
    logic        m_prev;
    logic [5:0]  m_hist;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) begin
            exp_bits[exp_len] = b[i];
            exp_tag[exp_len]  = tag;
            exp_len++;
        end
    endtask

    task automatic push_mark(input string tag);
        for (int i = 31; i >= 0; i--) begin
            exp_bits[exp_len] = MARK[i];
            exp_tag[exp_len]  = tag;
            exp_len++;
        end
    endtask

    task automatic clear_exp();
        exp_len = 0;
        exp_pos = 0;
    endtask

    // one clock: check outputs, then drive next inputs
    task automatic step(input logic want_en, input logic want_mode, input logic [1:0] want_rate);
        logic b, s, d;
        logic [6:0] w;
        logic [1:0] esym;
        @(negedge clk);
        cyc_n++;
        if (sym_vld) begin
            run_strobes++;
            if (last_cyc >= 0)
                chk((cyc_n - last_cyc) == exp_gap, "R2", "strobe gap", cyc_n - last_cyc, exp_gap);
            last_cyc = cyc_n;
            if (exp_pos >= exp_len) begin
                chk(1'b0, "R3", "strobe beyond expected stream", exp_pos, exp_len);
            end else begin
                b = exp_bits[exp_pos];
                s = b ^ m_scr[2] ^ m_scr[19];          // R7
                m_scr = {m_scr[18:0], s};
                d = s ^ m_prev;                         // R8
                m_prev = d;
                w = {d, m_hist};                        // R9
                esym = {^(w & 7'o171), ^(w & 7'o133)};
                m_hist = {d, m_hist[5:1]};
                chk(sym == esym, {exp_tag[exp_pos], " R7 R8 R9"}, "symbol", int'(sym), int'(esym));
                exp_pos++;
            end
        end
        if (hs_pend) begin
            src_idx++;
            n_acc++;
        end
        en        = want_en && (run_strobes < target_g);
        sync_mode = want_mode;
        rate_sel  = want_rate;
        in_valid  = (src_idx < src_n);
        in_data   = in_valid ? src_bytes[src_idx] : 8'h00;
        #1;
        hs_pend = in_valid && in_ready;
        if (in_ready) rdy_seen++;
    endtask

    task automatic run_scn(input logic mode0, input logic [1:0] rate,
                           input int target, input int switch_at);
        logic m;
        target_g = target;
        run_strobes = 0;
        last_cyc = -1;
        exp_gap = 1 << rate;
        n_acc = 0;
        rdy_seen = 0;
        m = mode0;
        for (int k = 0; k < 4000 && run_strobes < target; k++) begin
            m = (switch_at >= 0 && k >= switch_at) ? ~mode0 : mode0;
            step(1'b1, m, rate);
        end
        for (int k = 0; k < 4; k++) step(1'b0, m, rate);
        chk(run_strobes == target, "R2", "strobes in run", run_strobes, target);
    endtask

    task automatic load_src(input int n, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3,
                            input logic [7:0] b4, input logic [7:0] b5);
        src_bytes[0] = b0; src_bytes[1] = b1; src_bytes[2] = b2;
        src_bytes[3] = b3; src_bytes[4] = b4; src_bytes[5] = b5;
        src_n = n;
        src_idx = 0;
        hs_pend = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        en = 1'b0; sync_mode = 1'b0; rate_sel = 2'd0;
        in_valid = 1'b0; in_data = 8'h00;
        m_scr = '0; m_prev = 1'b0; m_hist = '0;
        hs_pend = 1'b0; src_n = 0; src_idx = 0;
        target_g = 0; run_strobes = 0; last_cyc = -1; exp_gap = 1;
        clear_exp();
        repeat (3) @(negedge clk);
        chk(sym_vld == 1'b0, "R1", "vld in reset", int'(sym_vld), 0);
        chk(in_ready == 1'b0, "R1", "ready in reset", int'(in_ready), 0);
        chk(sym == 2'b00, "R1", "sym in reset", int'(sym), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sym_vld == 1'b0 && sym == 2'b00, "R1", "idle after reset", int'(sym), 0);
    endtask

    task automatic t_enable_low();
        load_src(2, 8'h11, 8'h22, 8'h0, 8'h0, 8'h0, 8'h0);
        clear_exp();
        run_strobes = 0; rdy_seen = 0; n_acc = 0; last_cyc = -1;
        target_g = 1000;
        for (int k = 0; k < 40; k++) step(1'b0, 1'b0, 2'd0);
        chk(run_strobes == 0, "R3", "strobes while disabled", run_strobes, 0);
        chk(rdy_seen == 0, "R3", "ready while disabled", rdy_seen, 0);
    endtask

    task automatic t_sync_full();
        load_src(3, 8'hAA, 8'h55, 8'h12, 8'h0, 8'h0, 8'h0);
        clear_exp();
        push_mark("R4"); push_mark("R4"); push_mark("R4");
        run_scn(1'b1, 2'd0, 70, -1);
        chk(n_acc == 0, "R4", "bytes read in sync", n_acc, 0);
        chk(rdy_seen == 0, "R4", "ready in sync", rdy_seen, 0);
    endtask

    task automatic t_data_fill();
        load_src(6, 8'hA5, 8'hFF, 8'h00, 8'h3C, 8'h81, 8'h7E);
        clear_exp();
        push_byte(8'hA5, "R5"); push_byte(8'hFF, "R5"); push_byte(8'h00, "R5");
        push_byte(8'h3C, "R5"); push_byte(8'h81, "R5"); push_byte(8'h7E, "R5");
        for (int i = 0; i < 4; i++) push_byte(8'h00, "R6");
        run_scn(1'b0, 2'd0, 80, -1);
        chk(n_acc == 6, "R5", "bytes taken", n_acc, 6);
        chk(exp_pos == 80, "R6", "fill bits checked", exp_pos, 80);
    endtask

    task automatic t_rates();
        for (int r = 1; r < 4; r++) begin
            load_src(1, 8'hC6, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
            clear_exp();
            push_mark("R2");
            run_scn(1'b1, 2'(r), 12, -1);
        end
        load_src(2, 8'h69, 8'hF0, 8'h0, 8'h0, 8'h0, 8'h0);
        clear_exp();
        push_byte(8'h69, "R2"); push_byte(8'hF0, "R2");
        run_scn(1'b0, 2'd2, 16, -1);
        chk(n_acc == 2, "R5", "bytes at quarter rate", n_acc, 2);
    endtask

    task automatic t_sync_to_data();
        load_src(2, 8'hC3, 8'h5A, 8'h0, 8'h0, 8'h0, 8'h0);
        clear_exp();
        push_mark("R10");
        push_byte(8'hC3, "R10"); push_byte(8'h5A, "R10"); push_byte(8'h00, "R6");
        run_scn(1'b1, 2'd0, 56, 5);
        chk(n_acc == 2, "R10", "bytes after switch to data", n_acc, 2);
    endtask

    task automatic t_data_to_sync();
        load_src(2, 8'h96, 8'h0F, 8'h0, 8'h0, 8'h0, 8'h0);
        clear_exp();
        push_byte(8'h96, "R10");
        push_mark("R10"); push_mark("R4");
        run_scn(1'b0, 2'd0, 48, 3);
        chk(n_acc == 1, "R10", "bytes before switch to sync", n_acc, 1);
    endtask

    task automatic t_restart();
        load_src(1, 8'hE1, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
        clear_exp();
        push_byte(8'hE1, "R11");
        run_scn(1'b0, 2'd0, 4, -1);
        chk(n_acc == 1, "R11", "first byte taken", n_acc, 1);
        load_src(1, 8'h4B, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
        clear_exp();
        push_byte(8'h4B, "R11"); push_byte(8'h00, "R6");
        run_scn(1'b0, 2'd1, 16, -1);
        chk(n_acc == 1, "R11", "fresh byte after restart", n_acc, 1);
    endtask

    initial begin
        t_reset();
        t_enable_low();
        t_sync_full();
        t_data_fill();
        t_rates();
        t_sync_to_data();
        t_data_to_sync();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule